// File: doc/BRIEF.md
# Early-Release Physical Register Tracker

This block follows every physical register of an out-of-order core through its life and puts it back in the free pool as early as is safe. A register can return to the pool before the next writer of its logical register commits. Each register carries four pieces of state: a completion flag, an unmap flag, a count of readers still in flight and a count of live map-table checkpoints that still name it. The register goes back to the pool in the same clock edge that leaves both flags set and both counts at zero.

Rename asks for a destination register through the allocation port. The port grants the lowest-indexed free register and removes it from the pool at the next edge. The completion flag is set by writeback. The unmap flag is set when a later writer commits. A narrow-inline release comes from writeback when the result was small enough to live in the map table, and it sets both flags at once. The reader and checkpoint counts move on add and release events. A duplicate release of a register that is already free leaves the pool untouched.

Each register entry is a small state machine with three states. PR_FREE means the register sits in the pool. PR_PEND means it is allocated and still lacks completion, unmap or both. PR_HELD means both flags are set but readers or checkpoint references remain. The transitions are:
- alloc: PR_FREE to PR_PEND.
- settle: PR_PEND to PR_HELD, when both flags become set while a count is nonzero.
- drain: PR_HELD to PR_FREE, when the last count reaches zero.
- direct release: PR_PEND to PR_FREE, when the final flag lands with both counts already zero.

Top module: `erpt_tracker`

## Requirements
- R1: After reset, registers 0 to NUM_ARCH-1 (default 32) hold the architectural mapping with the completion flag set and the unmap flag clear. All other registers are free, so free_count reads 64 - 32 = 32.
- R2: While alloc_req is high and a register is free, alloc_gnt is high and alloc_id is the lowest free index. That register leaves the pool at the clock edge. With no free register, alloc_gnt is low.
- R3: A register returns to the pool only when four conditions hold together: completion set, unmap set, reader count zero and checkpoint count zero. It returns at the edge where the last condition is met, and free_count reflects it in the following cycle.
- R4: On the conventional path, a writeback event followed by an unmap event from the next writer's commit frees a register that has no references.
- R5: A narrow-inline release sets both the completion and unmap flags, so it alone frees a register with no references, including an architectural register present from reset.
- R6: Any release or flag event aimed at a register that is already free is ignored. free_count does not change and the register is not added to the pool twice.
- R7: A nonzero reader count holds a complete, unmapped register out of the pool until the last reader releases it.
- R8: A nonzero checkpoint reference count holds a complete, unmapped register out of the pool until the last checkpoint reference is dropped.
- R9: A reader or checkpoint decrement at a count of zero, without an increment on the same register in the same cycle, leaves the count at zero. It raises underflow_err for exactly the following cycle.
- R10: Allocation clears both flags and both counts. After reallocation, an unmap event alone does not free the register.
- R11: An increment and a decrement on the same counter of the same register in one cycle leave the count unchanged and raise no underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Rename requests a destination register |
| alloc_gnt | output | 1 | A register is granted this cycle |
| alloc_id | output | 6 | Index of the granted register (lowest free) |
| wb_vld | input | 1 | Writeback-complete event |
| wb_id | input | 6 | Register that completed |
| unmap_vld | input | 1 | Unmap event from a later writer's commit |
| unmap_id | input | 6 | Register that lost its mapping |
| narrow_vld | input | 1 | Narrow-inline release event |
| narrow_id | input | 6 | Register whose value was inlined |
| rd_add_vld | input | 1 | A reader of a register entered the window |
| rd_add_id | input | 6 | Register gaining a reader |
| rd_rel_vld | input | 1 | A reader has read its operand |
| rd_rel_id | input | 6 | Register losing a reader |
| ck_inc_vld | input | 1 | A checkpoint now references a register |
| ck_inc_id | input | 6 | Register gaining a checkpoint reference |
| ck_dec_vld | input | 1 | A checkpoint referencing a register was discarded |
| ck_dec_id | input | 6 | Register losing a checkpoint reference |
| free_count | output | 7 | Number of registers in the pool |
| underflow_err | output | 1 | A decrement at zero occurred in the previous cycle |

## Verification
A corrupted flag or count inside an entry shows up at the ports in one of two ways. A register may return to the pool too early, which raises free_count and makes alloc_id point at a register still in use. Or a register may never return, which leaves free_count low from then on. Both effects appear one cycle after the event that should or should not have released the register, and a stale pool bit also moves the lowest-index grant on the very next request. The bench keeps its own per-register model, so a single misplaced release is caught at the cycle it takes effect, not when the pool runs dry.

// File: rtl/erpt_pkg.sv
package erpt_pkg;

    typedef enum logic [1:0] {
        PR_FREE = 2'd0,
        PR_PEND = 2'd1,
        PR_HELD = 2'd2
    } preg_state_e;

endpackage

// File: rtl/erpt_entry.sv
module erpt_entry
    import erpt_pkg::*;
#(
    parameter int RD_W      = 4,
    parameter int CK_W      = 3,
    parameter bit INIT_LIVE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alloc_hit,
    input  logic wb_hit,
    input  logic unmap_hit,
    input  logic narrow_hit,
    input  logic rd_inc,
    input  logic rd_dec,
    input  logic ck_inc,
    input  logic ck_dec,
    output logic is_free,
    output logic underflow
);

    localparam logic [RD_W-1:0] RD_MAX = {RD_W{1'b1}};
    localparam logic [CK_W-1:0] CK_MAX = {CK_W{1'b1}};

    preg_state_e     st_q, st_d;
    logic            cmp_q, cmp_d;
    logic            unm_q, unm_d;
    logic [RD_W-1:0] rd_q, rd_d, rd_step;
    logic [CK_W-1:0] ck_q, ck_d, ck_step;
    logic            rd_uf, ck_uf;

    // saturating counter steps
    always_comb begin
        rd_step = rd_q;
        if (rd_inc && !rd_dec && rd_q != RD_MAX) rd_step = rd_q + RD_W'(1);
        else if (rd_dec && !rd_inc && rd_q != '0) rd_step = rd_q - RD_W'(1);
        ck_step = ck_q;
        if (ck_inc && !ck_dec && ck_q != CK_MAX) ck_step = ck_q + CK_W'(1);
        else if (ck_dec && !ck_inc && ck_q != '0) ck_step = ck_q - CK_W'(1);
    end

    assign rd_uf     = rd_dec && !rd_inc && (rd_q == '0);
    assign ck_uf     = ck_dec && !ck_inc && (ck_q == '0);
    assign underflow = rd_uf | ck_uf;

    // next-state process
    always_comb begin
        st_d  = st_q;
        cmp_d = cmp_q;
        unm_d = unm_q;
        rd_d  = rd_q;
        ck_d  = ck_q;
        unique case (st_q)
            PR_FREE: begin
                if (alloc_hit) begin
                    st_d  = PR_PEND;
                    cmp_d = 1'b0;
                    unm_d = 1'b0;
                    rd_d  = '0;
                    ck_d  = '0;
                end
            end
            PR_PEND, PR_HELD: begin
                cmp_d = cmp_q | wb_hit | narrow_hit;
                unm_d = unm_q | unmap_hit | narrow_hit;
                rd_d  = rd_step;
                ck_d  = ck_step;
                if (cmp_d && unm_d) begin
                    if (rd_d == '0 && ck_d == '0) st_d = PR_FREE;
                    else                          st_d = PR_HELD;
                end else begin
                    st_d = PR_PEND;
                end
            end
            default: st_d = PR_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= INIT_LIVE ? PR_PEND : PR_FREE;
            cmp_q <= INIT_LIVE;
            unm_q <= 1'b0;
            rd_q  <= '0;
            ck_q  <= '0;
        end else begin
            st_q  <= st_d;
            cmp_q <= cmp_d;
            unm_q <= unm_d;
            rd_q  <= rd_d;
            ck_q  <= ck_d;
        end
    end

    // output process
    always_comb begin
        is_free = (st_q == PR_FREE);
    end

endmodule

// File: rtl/erpt_pick.sv
module erpt_pick #(
    parameter int N    = 64,
    parameter int ID_W = $clog2(N),
    parameter int CN_W = $clog2(N + 1)
) (
    input  logic [N-1:0]    free_vec,
    output logic            any_free,
    output logic [ID_W-1:0] low_id,
    output logic [CN_W-1:0] count
);

    always_comb begin
        low_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) low_id = ID_W'(i);
        end
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CN_W'(free_vec[i]);
        end
    end

    assign any_free = |free_vec;

endmodule

// File: rtl/erpt_tracker.sv
module erpt_tracker #(
    parameter int NUM_PREGS = 64,
    parameter int NUM_ARCH  = 32,
    parameter int RD_W      = 4,
    parameter int CK_W      = 3,
    localparam int ID_W     = $clog2(NUM_PREGS),
    localparam int CN_W     = $clog2(NUM_PREGS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_req,
    output logic            alloc_gnt,
    output logic [ID_W-1:0] alloc_id,
    input  logic            wb_vld,
    input  logic [ID_W-1:0] wb_id,
    input  logic            unmap_vld,
    input  logic [ID_W-1:0] unmap_id,
    input  logic            narrow_vld,
    input  logic [ID_W-1:0] narrow_id,
    input  logic            rd_add_vld,
    input  logic [ID_W-1:0] rd_add_id,
    input  logic            rd_rel_vld,
    input  logic [ID_W-1:0] rd_rel_id,
    input  logic            ck_inc_vld,
    input  logic [ID_W-1:0] ck_inc_id,
    input  logic            ck_dec_vld,
    input  logic [ID_W-1:0] ck_dec_id,
    output logic [CN_W-1:0] free_count,
    output logic            underflow_err
);

    logic [NUM_PREGS-1:0] free_vec;
    logic [NUM_PREGS-1:0] uf_vec;
    logic                 any_free;
    logic [ID_W-1:0]      low_id;

    erpt_pick #(
        .N   (NUM_PREGS),
        .ID_W(ID_W),
        .CN_W(CN_W)
    ) u_pick (
        .free_vec(free_vec),
        .any_free(any_free),
        .low_id  (low_id),
        .count   (free_count)
    );

    assign alloc_gnt = alloc_req && any_free;
    assign alloc_id  = low_id;

    for (genvar i = 0; i < NUM_PREGS; i++) begin : g_reg
        logic alloc_hit;
        assign alloc_hit = alloc_gnt && (low_id == ID_W'(i));

        erpt_entry #(
            .RD_W     (RD_W),
            .CK_W     (CK_W),
            .INIT_LIVE(i < NUM_ARCH)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_hit (alloc_hit),
            .wb_hit    (wb_vld     && (wb_id     == ID_W'(i))),
            .unmap_hit (unmap_vld  && (unmap_id  == ID_W'(i))),
            .narrow_hit(narrow_vld && (narrow_id == ID_W'(i))),
            .rd_inc    (rd_add_vld && (rd_add_id == ID_W'(i))),
            .rd_dec    (rd_rel_vld && (rd_rel_id == ID_W'(i))),
            .ck_inc    (ck_inc_vld && (ck_inc_id == ID_W'(i))),
            .ck_dec    (ck_dec_vld && (ck_dec_id == ID_W'(i))),
            .is_free   (free_vec[i]),
            .underflow (uf_vec[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) underflow_err <= 1'b0;
        else        underflow_err <= |uf_vec;
    end

endmodule

// File: rtl/erpt_checker.sv
module erpt_checker #(
    parameter int CN_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            alloc_req,
    input logic            alloc_gnt,
    input logic [CN_W-1:0] free_count,
    input logic            underflow_err,
    input logic            wb_vld,
    input logic            unmap_vld,
    input logic            narrow_vld,
    input logic            rd_rel_vld,
    input logic            ck_dec_vld
);

    AST_GNT_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |-> (free_count != '0)); // R2

    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |-> alloc_req); // R2

    AST_NO_DROP_WITHOUT_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_gnt |=> (free_count >= $past(free_count))); // R2

    AST_DROP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |=> ((free_count + CN_W'(1)) >= $past(free_count))); // R2

    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (free_count > $past(free_count)) |->
            $past(wb_vld || unmap_vld || narrow_vld || rd_rel_vld || ck_dec_vld)); // R3

    AST_ERR_NEEDS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |-> $past(rd_rel_vld || ck_dec_vld)); // R9

endmodule

bind erpt_tracker erpt_checker #(.CN_W(CN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_req    (alloc_req),
    .alloc_gnt    (alloc_gnt),
    .free_count   (free_count),
    .underflow_err(underflow_err),
    .wb_vld       (wb_vld),
    .unmap_vld    (unmap_vld),
    .narrow_vld   (narrow_vld),
    .rd_rel_vld   (rd_rel_vld),
    .ck_dec_vld   (ck_dec_vld)
);

// File: tb/erpt_tracker_test.sv
module erpt_tracker_test;

    localparam int N    = 64;
    localparam int ARCH = 32;
    localparam int RDM  = 15;
    localparam int CKM  = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req = 1'b0;
    logic       alloc_gnt;
    logic [5:0] alloc_id;
    logic       wb_vld = 1'b0, unmap_vld = 1'b0, narrow_vld = 1'b0;
    logic       rd_add_vld = 1'b0, rd_rel_vld = 1'b0, ck_inc_vld = 1'b0, ck_dec_vld = 1'b0;
    logic [5:0] wb_id = '0, unmap_id = '0, narrow_id = '0;
    logic [5:0] rd_add_id = '0, rd_rel_id = '0, ck_inc_id = '0, ck_dec_id = '0;
    logic [6:0] free_count;
    logic       underflow_err;

    int checks = 0;
    int fails  = 0;

    // reference model
    bit m_live [N];
    bit m_cmp  [N];
    bit m_unm  [N];
    int m_rd   [N];
    int m_ck   [N];
    bit m_err;

    always #10 clk = ~clk;

    erpt_tracker uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_id(alloc_id),
        .wb_vld(wb_vld), .wb_id(wb_id),
        .unmap_vld(unmap_vld), .unmap_id(unmap_id),
        .narrow_vld(narrow_vld), .narrow_id(narrow_id),
        .rd_add_vld(rd_add_vld), .rd_add_id(rd_add_id),
        .rd_rel_vld(rd_rel_vld), .rd_rel_id(rd_rel_id),
        .ck_inc_vld(ck_inc_vld), .ck_inc_id(ck_inc_id),
        .ck_dec_vld(ck_dec_vld), .ck_dec_id(ck_dec_id),
        .free_count(free_count), .underflow_err(underflow_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < N; i++) if (!m_live[i]) c++;
        return c;
    endfunction

    function automatic int m_low();
        for (int i = 0; i < N; i++) if (!m_live[i]) return i;
        return -1;
    endfunction

    function automatic int cstep(input int v, input bit inc, input bit dec, input int mx);
        if (inc && !dec && v != mx) return v + 1;
        if (dec && !inc && v != 0) return v - 1;
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_live[i] = (i < ARCH);
            m_cmp[i]  = (i < ARCH);
            m_unm[i]  = 1'b0;
            m_rd[i]   = 0;
            m_ck[i]   = 0;
        end
        m_err = 1'b0;
    endtask

    task automatic model_step();
        int  g = (alloc_req && m_count() > 0) ? m_low() : -1;
        bit  e = 1'b0;
        for (int i = 0; i < N; i++) begin
            bit ri = rd_add_vld && rd_add_id == i;
            bit rr = rd_rel_vld && rd_rel_id == i;
            bit ci = ck_inc_vld && ck_inc_id == i;
            bit cd = ck_dec_vld && ck_dec_id == i;
            if ((rr && !ri && m_rd[i] == 0) || (cd && !ci && m_ck[i] == 0)) e = 1'b1;
            if (!m_live[i]) begin
                if (g == i) begin
                    m_live[i] = 1'b1; m_cmp[i] = 1'b0; m_unm[i] = 1'b0;
                    m_rd[i] = 0; m_ck[i] = 0;
                end
            end else begin
                m_cmp[i] = m_cmp[i] | (wb_vld && wb_id == i) | (narrow_vld && narrow_id == i);
                m_unm[i] = m_unm[i] | (unmap_vld && unmap_id == i) | (narrow_vld && narrow_id == i);
                m_rd[i]  = cstep(m_rd[i], ri, rr, RDM);
                m_ck[i]  = cstep(m_ck[i], ci, cd, CKM);
                if (m_cmp[i] && m_unm[i] && m_rd[i] == 0 && m_ck[i] == 0) m_live[i] = 1'b0;
            end
        end
        m_err = e;
    endtask

    task automatic idle();
        alloc_req = 0; wb_vld = 0; unmap_vld = 0; narrow_vld = 0;
        rd_add_vld = 0; rd_rel_vld = 0; ck_inc_vld = 0; ck_dec_vld = 0;
    endtask

    // one cycle: inputs already driven in the low phase
    task automatic cycle();
        #1;
        check("R2 grant", int'(alloc_gnt), int'(alloc_req && m_count() > 0));
        if (alloc_req && m_count() > 0) check("R2 lowest id", int'(alloc_id), m_low());
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R3 free_count", int'(free_count), m_count());
        check("R9 underflow_err", int'(underflow_err), int'(m_err));
        idle();
    endtask

    task automatic alloc1();
        alloc_req = 1; cycle();
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        model_reset();
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 reset free_count", int'(free_count), 32);
        alloc_req = 1; #1;
        check("R1 first grant id", int'(alloc_id), 32);
        idle();

        // R2 allocate 32
        alloc1();
        check("R2 count after alloc", int'(free_count), 31);

        // R3/R4 wb alone keeps it, unmap frees
        wb_vld = 1; wb_id = 32; cycle();
        check("R3 complete only stays", int'(free_count), 31);
        unmap_vld = 1; unmap_id = 32; cycle();
        check("R4 wb+unmap frees", int'(free_count), 32);

        // R6 duplicate releases on free register
        unmap_vld = 1; unmap_id = 32; narrow_vld = 1; narrow_id = 32; wb_vld = 1; wb_id = 32; cycle();
        check("R6 duplicate ignored", int'(free_count), 32);
        alloc_req = 1; #1;
        check("R6 pool intact id", int'(alloc_id), 32);
        idle();

        // R10 reallocation clears flags
        alloc1();
        unmap_vld = 1; unmap_id = 32; cycle();
        check("R10 unmap alone after realloc", int'(free_count), 31);
        wb_vld = 1; wb_id = 32; cycle();
        check("R10 then complete frees", int'(free_count), 32);

        // R7 readers delay release
        alloc1();
        rd_add_vld = 1; rd_add_id = 32; cycle();
        narrow_vld = 1; narrow_id = 32; cycle();
        check("R7 reader holds", int'(free_count), 31);
        rd_rel_vld = 1; rd_rel_id = 32; cycle();
        check("R7 last reader frees", int'(free_count), 32);

        // R8 checkpoint refs delay release
        alloc1();
        ck_inc_vld = 1; ck_inc_id = 32; cycle();
        wb_vld = 1; wb_id = 32; unmap_vld = 1; unmap_id = 32; cycle();
        check("R8 checkpoint holds", int'(free_count), 31);
        ck_dec_vld = 1; ck_dec_id = 32; cycle();
        check("R8 checkpoint drop frees", int'(free_count), 32);

        // R9 underflow
        rd_rel_vld = 1; rd_rel_id = 40; cycle();
        check("R9 err raised", int'(underflow_err), 1);
        check("R9 count untouched", int'(free_count), 32);
        cycle();
        check("R9 err one cycle", int'(underflow_err), 0);
        ck_dec_vld = 1; ck_dec_id = 3; cycle();
        check("R9 ckpt err raised", int'(underflow_err), 1);

        // R11 inc and dec together
        alloc1();
        rd_add_vld = 1; rd_add_id = 32; rd_rel_vld = 1; rd_rel_id = 32; cycle();
        check("R11 no underflow", int'(underflow_err), 0);
        narrow_vld = 1; narrow_id = 32; cycle();
        check("R11 count stayed zero", int'(free_count), 32);

        // R5 narrow on architectural register
        narrow_vld = 1; narrow_id = 5; cycle();
        check("R5 narrow frees arch reg", int'(free_count), 33);
        alloc_req = 1; #1;
        check("R5 freed reg is lowest", int'(alloc_id), 5);
        idle();

        // R2 exhaust pool
        for (int k = 0; k < 33; k++) alloc1();
        check("R2 pool empty", int'(free_count), 0);
        alloc_req = 1; #1;
        check("R2 no grant when empty", int'(alloc_gnt), 0);
        idle();

        // constrained random phase
        for (int k = 0; k < 4000; k++) begin
            alloc_req  = ($urandom % 3) == 0;
            wb_vld     = ($urandom % 3) == 0; wb_id     = 6'($urandom);
            unmap_vld  = ($urandom % 3) == 0; unmap_id  = 6'($urandom);
            narrow_vld = ($urandom % 6) == 0; narrow_id = 6'($urandom);
            rd_add_vld = ($urandom % 4) == 0; rd_add_id = 6'($urandom);
            rd_rel_vld = ($urandom % 4) == 0; rd_rel_id = 6'($urandom);
            ck_inc_vld = ($urandom % 6) == 0; ck_inc_id = 6'($urandom);
            ck_dec_vld = ($urandom % 6) == 0; ck_dec_id = 6'($urandom);
            cycle();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule